// File: doc/BRIEF.md
# Display RAM address generator

This block produces the write address for a display memory of 65 rows by 133 columns, stored as byte-wide banks. A column pointer picks one of 133 columns. A bank pointer picks one of nine banks. Banks 0 to 7 each hold eight rows, so bank n holds rows 8n to 8n+7. Bank 8 is a single-row bank that holds the icon row (row 64).

A host loads the pointers with separate set-column and set-bank strobes. The column value arrives as a 7-bit low part plus a separate top bit, which together give an 8-bit column number. After every data write the pointers advance on their own, so a bulk fill needs no further addressing.

In horizontal mode the column pointer steps and carries into the bank pointer. In vertical mode the bank pointer steps and carries into the column pointer. The RAM receives a write enable, the bank and column address, and the data byte. In the icon bank only bit 0 of that byte is kept.

Top module: `dram_addr_gen`

## Requirements
- R1: After reset the bank pointer (`ramBank`) is 0 and the column pointer (`ramCol`) is 0.
- R2: A set-column strobe with value {setXMsb, setXLow} of at most 132 loads the column pointer on the next clock edge. A set-bank strobe with a value of at most 8 loads the bank pointer on the next clock edge.
- R3: A set-column value above 132, or a set-bank value above 8 (9 to 15), is ignored, and that pointer keeps its previous value.
- R4: `ramWe` equals `dataStb` in the same cycle. During a write, `ramBank` and `ramCol` show the address from before that write, and the pointers move on the following clock edge.
- R5: With `vertMode` = 0 during a write, the column pointer increments. When it is at 132 it becomes 0 and the bank pointer increments, and the bank pointer wraps from 8 to 0.
- R6: With `vertMode` = 1 during a write, the bank pointer increments. When it is at 8 it becomes 0 and the column pointer increments, and the column pointer wraps from 132 to 0.
- R7: When the bank pointer is 8 (icon bank), `ramData` bits 7 to 1 are 0 and bit 0 equals `dataIn[0]`. In every other bank `ramData` equals `dataIn`.
- R8: If a set strobe (column or bank) is high in the same cycle as `dataStb`, the write still happens at the current address, but no auto-advance takes place. Only the valid loads change the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setXStb | input | 1 | Load column pointer |
| setXLow | input | 7 | Column value, bits 6..0 |
| setXMsb | input | 1 | Column value, bit 7 |
| setYStb | input | 1 | Load bank pointer |
| setYVal | input | 4 | Bank value |
| dataStb | input | 1 | Data write strobe |
| dataIn | input | 8 | Data byte |
| vertMode | input | 1 | 0 horizontal, 1 vertical advance |
| ramWe | output | 1 | RAM write enable |
| ramBank | output | 4 | RAM bank address |
| ramCol | output | 8 | RAM column address |
| ramData | output | 8 | RAM write data |

## Verification
The assertions assume that the pointers only ever hold legal values. They also assume that the step checks apply only in cycles where a write happens with no set strobe, since a load then overrides the step. The stimulus draws column values from the full 8-bit range and bank values from the full 4-bit range, so out-of-range loads occur often and must be ignored. Strobes are mixed at random, including set-with-write collisions. Directed cases put the pointers at 132 and 8 so that both wrap paths are exercised in each mode.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
  typedef struct packed {
    logic loadX;
    logic loadY;
    logic advance;
  } ptrCtrl_t;
endpackage

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dram_addr_pkg::*;
#(
  parameter int NUM_COLS  = 133,
  parameter int NUM_BANKS = 9,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 4
) (
  input  logic              setXStb,
  input  logic [COL_W-1:0]  setXVal,
  input  logic              setYStb,
  input  logic [BANK_W-1:0] setYVal,
  input  logic              dataStb,
  output ptrCtrl_t          ctrl
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic xInRange;
  logic yInRange;

  always_comb begin
    xInRange     = (setXVal <= LAST_COL);
    yInRange     = (setYVal <= LAST_BANK);
    ctrl.loadX   = setXStb && xInRange;
    ctrl.loadY   = setYStb && yInRange;
    ctrl.advance = dataStb && !setXStb && !setYStb;
  end
endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_addr_pkg::*;
#(
  parameter int NUM_COLS  = 133,
  parameter int NUM_BANKS = 9,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrCtrl_t          ctrl,
  input  logic [COL_W-1:0]  setXVal,
  input  logic [BANK_W-1:0] setYVal,
  input  logic              vertMode,
  input  logic [DATA_W-1:0] dataIn,
  output logic [BANK_W-1:0] bankPtr,
  output logic [COL_W-1:0]  colPtr,
  output logic [DATA_W-1:0] dataOut
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [COL_W-1:0]  colInc;
  logic [BANK_W-1:0] bankInc;
  logic              colAtEnd;
  logic              bankAtEnd;
  logic [COL_W-1:0]  colNext;
  logic [BANK_W-1:0] bankNext;

  always_comb begin
    colAtEnd  = (colPtr == LAST_COL);
    bankAtEnd = (bankPtr == LAST_BANK);
    colInc    = colAtEnd ? '0 : colPtr + 1'b1;
    bankInc   = bankAtEnd ? '0 : bankPtr + 1'b1;
    colNext   = colPtr;
    bankNext  = bankPtr;
    if (ctrl.advance) begin
      if (!vertMode) begin
        colNext = colInc;
        if (colAtEnd) bankNext = bankInc;
      end else begin
        bankNext = bankInc;
        if (bankAtEnd) colNext = colInc;
      end
    end
    if (ctrl.loadX) colNext = setXVal;
    if (ctrl.loadY) bankNext = setYVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colPtr  <= '0;
      bankPtr <= '0;
    end else begin
      colPtr  <= colNext;
      bankPtr <= bankNext;
    end
  end

  // Icon bank keeps a single bit per column.
  generate
    if (DATA_W > 1) begin : g_iconMask
      always_comb begin
        dataOut = dataIn;
        if (bankPtr == LAST_BANK) dataOut[DATA_W-1:1] = '0;
      end
    end else begin : g_noMask
      always_comb dataOut = dataIn;
    end
  endgenerate

  // Pointers stay inside the legal space (R2, R3)
  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    colPtr <= LAST_COL);
  assert_bank_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bankPtr <= LAST_BANK);

  // Horizontal stepping (R5)
  assert_hstep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !vertMode && !colAtEnd) |=>
      (colPtr == $past(colPtr) + 1'b1) && $stable(bankPtr));
  assert_hwrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !vertMode && colAtEnd && !bankAtEnd) |=>
      (colPtr == '0) && (bankPtr == $past(bankPtr) + 1'b1));

  // Vertical stepping (R6)
  assert_vstep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && vertMode && !bankAtEnd) |=>
      (bankPtr == $past(bankPtr) + 1'b1) && $stable(colPtr));
  assert_vwrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && vertMode && bankAtEnd && !colAtEnd) |=>
      (bankPtr == '0) && (colPtr == $past(colPtr) + 1'b1));

  // Idle cycles leave both pointers alone (R4, R8)
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.advance && !ctrl.loadX && !ctrl.loadY) |=>
      $stable(colPtr) && $stable(bankPtr));
endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
  import dram_addr_pkg::*;
#(
  parameter int NUM_COLS  = 133,
  parameter int NUM_BANKS = 9,
  parameter int XLOW_W    = 7,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setXStb,
  input  logic [XLOW_W-1:0] setXLow,
  input  logic              setXMsb,
  input  logic              setYStb,
  input  logic [BANK_W-1:0] setYVal,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              vertMode,
  output logic              ramWe,
  output logic [BANK_W-1:0] ramBank,
  output logic [XLOW_W:0]   ramCol,
  output logic [DATA_W-1:0] ramData
);
  localparam int COL_W = XLOW_W + 1;
  localparam logic [BANK_W-1:0] ICON_BANK = BANK_W'(NUM_BANKS - 1);

  ptrCtrl_t         ctrl;
  logic [COL_W-1:0] setXVal;

  assign setXVal = {setXMsb, setXLow};
  assign ramWe   = dataStb;

  dram_addr_ctrl #(
    .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .COL_W(COL_W), .BANK_W(BANK_W)
  ) u_ctrl (
    .setXStb(setXStb), .setXVal(setXVal), .setYStb(setYStb),
    .setYVal(setYVal), .dataStb(dataStb), .ctrl(ctrl)
  );

  dram_addr_path #(
    .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .COL_W(COL_W),
    .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .setXVal(setXVal),
    .setYVal(setYVal), .vertMode(vertMode), .dataIn(dataIn),
    .bankPtr(ramBank), .colPtr(ramCol), .dataOut(ramData)
  );

  // Icon bank write carries bit 0 only (R7)
  assert_icon_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramBank == ICON_BANK) |->
      (ramData == DATA_W'(dataIn[0])));

  // Out-of-range bank load alone leaves the bank pointer unchanged (R3)
  assert_bad_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setYStb && setYVal > ICON_BANK && !dataStb) |=> $stable(ramBank));

  // Out-of-range column load alone leaves the column pointer unchanged (R3)
  assert_bad_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setXStb && {setXMsb, setXLow} > COL_W'(NUM_COLS - 1) && !dataStb) |=>
      $stable(ramCol));
endmodule

// File: tb/dram_addr_gen_bench.sv
module dram_addr_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setXStb = 1'b0;
  logic [6:0] setXLow = '0;
  logic       setXMsb = 1'b0;
  logic       setYStb = 1'b0;
  logic [3:0] setYVal = '0;
  logic       dataStb = 1'b0;
  logic [7:0] dataIn = '0;
  logic       vertMode = 1'b0;
  logic       ramWe;
  logic [3:0] ramBank;
  logic [7:0] ramCol;
  logic [7:0] ramData;

  int vecs = 0;
  int errs = 0;
  int expCol = 0;
  int expBank = 0;
  string lastTag = "R1";

  always #4 clk = ~clk;

  dram_addr_gen u_dram_addr_gen (
    .clk(clk), .rstN(rstN), .setXStb(setXStb), .setXLow(setXLow),
    .setXMsb(setXMsb), .setYStb(setYStb), .setYVal(setYVal),
    .dataStb(dataStb), .dataIn(dataIn), .vertMode(vertMode),
    .ramWe(ramWe), .ramBank(ramBank), .ramCol(ramCol), .ramData(ramData)
  );

  function automatic logic [7:0] expData(int bank, logic [7:0] d);
    return (bank == 8) ? {7'd0, d[0]} : d;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge, check before the rising edge,
  // then step the reference pointers.
  task automatic step(bit sx, int xv, bit sy, int yv, bit ds, logic [7:0] d, bit v);
    @(negedge clk);
    setXStb = sx; setXLow = xv[6:0]; setXMsb = xv[7];
    setYStb = sy; setYVal = yv[3:0];
    dataStb = ds; dataIn = d; vertMode = v;
    #1;
    chk({lastTag, " col"}, ramCol, expCol);
    chk({lastTag, " bank"}, ramBank, expBank);
    chk("R4 we", ramWe, ds);
    if (ds) chk("R7 data", ramData, expData(expBank, d));
    @(posedge clk);
    if (ds && !sx && !sy) begin
      if (!v) begin
        lastTag = "R5";
        if (expCol == 132) begin
          expCol = 0;
          expBank = (expBank == 8) ? 0 : expBank + 1;
        end else expCol++;
      end else begin
        lastTag = "R6";
        if (expBank == 8) begin
          expBank = 0;
          expCol = (expCol == 132) ? 0 : expCol + 1;
        end else expBank++;
      end
    end else begin
      lastTag = ds ? "R8" : "R4";
      if (sx) begin
        if (xv[7:0] <= 132) begin expCol = xv[7:0]; if (!ds) lastTag = "R2"; end
        else if (!ds) lastTag = "R3";
      end
      if (sy) begin
        if (yv[3:0] <= 8) begin expBank = yv[3:0]; if (!ds) lastTag = "R2"; end
        else if (!ds) lastTag = "R3";
      end
    end
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    step(0, 0, 0, 0, 0, 8'h00, 0);
    // R2 / R5 horizontal wrap, bank 8 to 0
    step(1, 132, 1, 8, 0, 8'h00, 0);
    step(0, 0, 0, 0, 1, 8'hFF, 0);   // R7 icon: expect 1
    step(0, 0, 0, 0, 1, 8'hA5, 0);   // now 0,0
    // R6 vertical wrap, col 132 to 0
    step(1, 132, 1, 7, 0, 8'h00, 1);
    step(0, 0, 0, 0, 1, 8'h3C, 1);
    step(0, 0, 0, 0, 1, 8'hFE, 1);   // R7 icon: expect 0
    step(0, 0, 0, 0, 0, 8'h00, 1);
    // R3 out-of-range loads
    step(1, 133, 0, 0, 0, 8'h00, 0);
    step(0, 0, 1, 9, 0, 8'h00, 0);
    step(1, 255, 1, 15, 0, 8'h00, 0);
    // R8 collision: load plus write, no advance
    step(1, 200, 0, 0, 1, 8'h11, 0);
    step(0, 0, 1, 3, 1, 8'h22, 1);
    step(0, 0, 0, 0, 0, 8'h00, 0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 10, $urandom_range(0, 255), (r >= 10 && r < 20) || r == 99,
           $urandom_range(0, 15), r >= 35, 8'($urandom), (i / 50) % 2 == 1);
    end
    @(negedge clk);
    dataStb = 0; setXStb = 0; setYStb = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule